// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block drives three inverter legs. Each leg has a high-side and a low-side switch. All six gate signals come from one half-period counter that counts down and then up. Each leg has its own duty setting. One dead-time setting applies to every leg, and it keeps the two switches of a leg apart around each edge. At every period start the block emits a sync pulse of programmable width, so that other logic can align its sampling to the switching pattern.

Software programs the block through a write-only port that takes an enable, an address and data. All timing settings are double-buffered. In single-update mode they take effect at each period start. In double-update mode they also take effect at the midpoint, so the two halves of a period can differ in length, duty and dead time. Writing the period register starts the counter. The gate outputs stay low until the period and all three duty settings have been written at least once.

Top module: `pwm3_timer`

## Requirements
- R1: After a synchronous reset every gate output and the sync output are low, and the counter does not run, so no sync pulse appears until the period register is written.
- R2: All six gate outputs stay low until the period register and the three duty registers have each been written at least once. After that, the outputs start at the next settings reload.
- R3: The first write to the period register (value P) starts the counter. The sync output first rises 1.5×P clock edges after the edge that takes the write in single-update mode, and P edges after it in double-update mode.
- R4: In single-update mode each half period lasts P cycles, so successive rising edges of the sync output are 2×P cycles apart.
- R5: In single-update mode, with duty D and dead time T, each period has 2×(D−T) cycles of high-side on-time and 2×(P−D−T) cycles of low-side on-time.
- R6: The high and low outputs of one leg are never high in the same cycle.
- R7: Each half-period on-time is clamped to the range 0 to P. For example, D ≤ T gives no high-side pulse, and D + T ≥ P gives no low-side pulse.
- R8: In single-update mode, a write made during a period does not change that period's waveform. It takes effect from the next period start.
- R9: In double-update mode, settings are also reloaded at the midpoint. The period lasts P1+P2 cycles, and high-side on-time is clamp(D1−T1)+clamp(D2−T2), where index 1 is the first half and index 2 the second half.
- R10: The sync pulse stays high for W+1 cycles, where W is the sync-width register.
- R11: The register addresses are: 0 period, 1 duty of leg A, 2 duty of leg B, 3 duty of leg C, 4 dead time, 5 sync width, 6 mode. In the mode register, bit 0 set to 1 selects double-update mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| pwm_hi | output | 3 | High-side gate signals, bit 0 is leg A |
| pwm_lo | output | 3 | Low-side gate signals, bit 0 is leg A |
| sync_o | output | 1 | Period-start sync pulse |

## Verification
The assertions check on every cycle that:
- the high and low outputs of a leg never overlap;
- the outputs stay low while configuration is incomplete;
- the counter stays below the active period and turns round only at its top;
- no sync pulse appears before the counter starts.

Only the bench scenarios can show the pulse-width arithmetic: on-times summed over whole periods in a sweep of duty and dead time, clamping at both ends, the delay before the first sync in each mode, the deferral of writes made mid-period, and the asymmetric periods built in double-update mode.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NPH = 3;

  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_DUTY_A = 3'd1,
    REG_DUTY_B = 3'd2,
    REG_DUTY_C = 3'd3,
    REG_DEAD   = 3'd4,
    REG_SYNCW  = 3'd5,
    REG_MODE   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_dbl,
  input  logic [CW-1:0] start_p,
  input  logic [CW-1:0] act_p,
  input  logic [CW-1:0] nxt_p,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          ev_start,
  output logic          ev_mid
);
  logic up;

  assign ev_start = running && up && (cnt == act_p - 1'b1);
  assign ev_mid   = running && !up && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      up      <= 1'b0;
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      if (start_dbl) begin
        up  <= 1'b1;
        cnt <= '0;
      end else begin
        up  <= 1'b0;
        cnt <= (start_p >> 1) - 1'b1;
      end
    end else if (running) begin
      if (ev_start) begin
        up  <= 1'b0;
        cnt <= nxt_p - 1'b1;
      end else if (ev_mid) begin
        up  <= 1'b1;
      end else if (up) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < act_p));

  assert_turn_top_R4: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && $past(up) && !up) |-> ($past(cnt) == $past(act_p) - 1'b1));
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] dead,
  output logic          hi,
  output logic          lo
);
  logic [CW-1:0] hi_thr;
  logic [CW:0]   lo_thr;

  always_comb begin
    hi_thr = (duty > dead) ? (duty - dead) : '0;
    lo_thr = {1'b0, duty} + {1'b0, dead};
  end

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= (cnt < hi_thr);
      lo <= ({1'b0, cnt} >= lo_thr);
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));
endmodule

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [CW-1:0] width,
  output logic          sync_o
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o <= 1'b0;
      left   <= '0;
    end else if (fire) begin
      sync_o <= 1'b1;
      left   <= width;
    end else if (left != '0) begin
      left   <= left - 1'b1;
    end else begin
      sync_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [2:0]    pwm_hi,
  output logic [2:0]    pwm_lo,
  output logic          sync_o
);
  localparam int NSEEN = NPH + 1;

  logic [CW-1:0] sh_p, sh_dt, act_p, act_dt, sync_w;
  logic [CW-1:0] sh_d  [NPH];
  logic [CW-1:0] act_d [NPH];
  logic [NSEEN-1:0] seen;
  logic dbl, armed;
  logic [CW-1:0] cnt;
  logic running, ev_start, ev_mid, start, reload, all_seen;

  assign all_seen = &seen;
  assign start    = wr_en && (reg_addr_e'(wr_addr) == REG_PERIOD) && !running;
  assign reload   = ev_start || (ev_mid && dbl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_p   <= '0;
      sh_dt  <= '0;
      act_p  <= '0;
      act_dt <= '0;
      sync_w <= '0;
      seen   <= '0;
      dbl    <= 1'b0;
      armed  <= 1'b0;
      for (int i = 0; i < NPH; i++) begin
        sh_d[i]  <= '0;
        act_d[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          REG_PERIOD: begin
            sh_p    <= wr_data;
            seen[0] <= 1'b1;
          end
          REG_DEAD:  sh_dt  <= wr_data;
          REG_SYNCW: sync_w <= wr_data;
          REG_MODE:  dbl    <= wr_data[0];
          default: ;
        endcase
        for (int i = 0; i < NPH; i++) begin
          if (wr_addr == 3'(i + 1)) begin
            sh_d[i]   <= wr_data;
            seen[i+1] <= 1'b1;
          end
        end
      end
      if (start) begin
        act_p <= wr_data;
      end else if (reload) begin
        act_p  <= sh_p;
        act_dt <= sh_dt;
        armed  <= all_seen;
        for (int i = 0; i < NPH; i++) act_d[i] <= sh_d[i];
      end
    end
  end

  pwm3_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .start_dbl(dbl), .start_p(wr_data),
    .act_p(act_p), .nxt_p(sh_p), .cnt(cnt), .running(running),
    .ev_start(ev_start), .ev_mid(ev_mid)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    pwm3_phase #(.CW(CW)) u_ph (
      .clk(clk), .rst(rst), .armed(armed), .cnt(cnt), .duty(act_d[g]),
      .dead(act_dt), .hi(pwm_hi[g]), .lo(pwm_lo[g])
    );
  end

  pwm3_sync #(.CW(CW)) u_sync (
    .clk(clk), .rst(rst), .fire(ev_start), .width(sync_w), .sync_o(sync_o)
  );

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !all_seen |-> (pwm_hi == '0 && pwm_lo == '0));

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> !sync_o);
endmodule

// File: tb/pwm3_timer_test.sv
`timescale 1ns/1ps
module pwm3_timer_test;
  localparam int CW = 10;
  localparam int P  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0] pwm_hi, pwm_lo;
  logic sync_o;
  int total = 0;
  int bad = 0;
  int overlaps = 0;

  always #5 clk = ~clk;

  pwm3_timer #(.CW(CW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sync_o(sync_o)
  );

  always @(negedge clk) if (!rst && ((pwm_hi & pwm_lo) != 3'b000)) overlaps++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Waits for a sync rise, then counts one period window; optional writes at samples 1..nw
  task automatic measure(output int per, output int hc [3], output int lc [3],
                         input int nw, input logic [2:0] wa [3], input int wd [3]);
    logic prev;
    int idx;
    per = 0;
    for (int i = 0; i < 3; i++) begin hc[i] = 0; lc[i] = 0; end
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (sync_o && !prev) break;
      prev = sync_o;
    end
    idx = 0; prev = 1'b1;
    forever begin
      @(negedge clk);
      idx++;
      if (idx <= nw) begin
        wr_en = 1'b1; wr_addr = wa[idx-1]; wr_data = CW'(wd[idx-1]);
      end else wr_en = 1'b0;
      per++;
      for (int i = 0; i < 3; i++) begin hc[i] += int'(pwm_hi[i]); lc[i] += int'(pwm_lo[i]); end
      if (sync_o && !prev) break;
      prev = sync_o;
    end
    wr_en = 1'b0;
  endtask

  task automatic sync_len(output int n);
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (sync_o && !prev) break;
      prev = sync_o;
    end
    n = 0;
    while (sync_o) begin n++; @(negedge clk); end
  endtask

  task automatic first_sync(output int edges, output int outs);
    int n;
    n = 1; outs = 0;
    while (!sync_o && n < 1000) begin
      @(negedge clk); n++;
      if (pwm_hi != 0 || pwm_lo != 0) outs++;
    end
    edges = n - 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, edges, outs, n, sy;
    int hc [3];
    int lc [3];
    int dv [3];
    logic [2:0] na [3];
    int nd [3];
    na = '{3'd0, 3'd0, 3'd0};
    nd = '{0, 0, 0};

    do_reset();
    // R1: reset state and stopped counter
    check("R1 hi after reset", int'(pwm_hi), 0);
    check("R1 lo after reset", int'(pwm_lo), 0);
    check("R1 sync after reset", int'(sync_o), 0);
    sy = 0;
    repeat (40) begin @(negedge clk); if (sync_o) sy++; end
    check("R1 no sync while stopped", sy, 0);

    // R3 single: R11 address 0 is period
    wr(3'd0, P);
    first_sync(edges, outs);
    check("R3 first sync single", edges, 3 * P / 2);
    check("R2 gated before duties", outs, 0);
    measure(per, hc, lc, 0, na, nd);
    check("R2 still gated, period only", hc[0] + lc[0] + hc[1] + lc[1] + hc[2] + lc[2], 0);

    // R11: dead=4, duties 1..3
    wr(3'd4, 1); wr(3'd1, 4); wr(3'd2, 2); wr(3'd3, 7);
    measure(per, hc, lc, 0, na, nd);
    measure(per, hc, lc, 0, na, nd);
    check("R4 period single", per, 2 * P);
    check("R5 leg A hi", hc[0], 6);
    check("R5 leg A lo", lc[0], 6);
    check("R5 leg B hi", hc[1], 2);
    check("R5 leg B lo", lc[1], 10);
    check("R7 leg C hi", hc[2], 12);
    check("R7 leg C lo", lc[2], 0);

    // R5/R7 sweep of duty and dead time
    for (int dt = 0; dt < 3; dt++) begin
      for (int d = 0; d <= P + 1; d++) begin
        dv = '{d, P + 1 - d, d / 2};
        wr(3'd4, dt); wr(3'd1, dv[0]); wr(3'd2, dv[1]); wr(3'd3, dv[2]);
        measure(per, hc, lc, 0, na, nd);
        measure(per, hc, lc, 0, na, nd);
        check("R4 sweep period", per, 2 * P);
        for (int i = 0; i < 3; i++) begin
          check((dv[i] <= dt || dv[i] >= P - dt) ? "R7 sweep hi" : "R5 sweep hi",
                hc[i], 2 * clampi(dv[i] - dt, P));
          check((dv[i] <= dt || dv[i] >= P - dt) ? "R7 sweep lo" : "R5 sweep lo",
                lc[i], 2 * clampi(P - dv[i] - dt, P));
        end
      end
    end

    // R8: mid-period write is deferred
    wr(3'd4, 0); wr(3'd1, 3);
    measure(per, hc, lc, 0, na, nd);
    measure(per, hc, lc, 1, '{3'd1, 3'd0, 3'd0}, '{6, 0, 0});
    check("R8 period with write keeps old duty", hc[0], 6);
    measure(per, hc, lc, 0, na, nd);
    check("R8 next period uses new duty", hc[0], 12);

    // R10: sync width, R11 address 5
    wr(3'd5, 3);
    measure(per, hc, lc, 0, na, nd);
    sync_len(n);
    check("R10 sync width 3", n, 4);
    wr(3'd5, 0);
    measure(per, hc, lc, 0, na, nd);
    sync_len(n);
    check("R10 sync width 0", n, 1);

    // R9: double update, R11 address 6 bit 0
    wr(3'd6, 1); wr(3'd4, 1); wr(3'd1, 5); wr(3'd2, 5); wr(3'd3, 5);
    measure(per, hc, lc, 0, na, nd);
    measure(per, hc, lc, 0, na, nd);
    check("R9 symmetric double period", per, 2 * P);
    measure(per, hc, lc, 3, '{3'd0, 3'd1, 3'd4}, '{6, 2, 0});
    check("R9 asymmetric period", per, P + 6);
    check("R9 leg A hi", hc[0], 4 + 2);
    check("R9 leg A lo", lc[0], 2 + 4);
    check("R9 leg B hi", hc[1], 4 + 5);
    check("R9 leg B lo", lc[1], 2 + 1);
    measure(per, hc, lc, 0, na, nd);
    check("R9 following period", per, 12);
    check("R9 following leg A hi", hc[0], 4);

    // R3 double mode start
    do_reset();
    check("R1 hi after second reset", int'(pwm_hi), 0);
    wr(3'd6, 1);
    wr(3'd0, P);
    first_sync(edges, outs);
    check("R3 first sync double", edges, P);

    check("R6 no overlap seen", overlaps, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule